// File: doc/BRIEF.md
# Chainable Byte Timer with Calendar Clock

This peripheral has two 8-bit up-counters and a calendar clock. Software reaches all of them through one byte-wide register port. In timer mode, each counter advances on its own tick input. Setting the chain bit joins the two counters into one 16-bit count: the upper counter then moves only when the lower one wraps from its maximum.

With the calendar enabled, a one-second tick input drives second, minute, hour, weekday, day, month and a 16-bit year. The year is split across two byte registers. The calendar wraps months of 28, 29, 30 and 31 days correctly, and it follows the full Gregorian leap rule.

One interrupt flag records the selected event. The output pin shows the flag only while the enable bit is set. Software clears the flag by writing zero to it.

Top module: `rtc_cascade_timer`

## Requirements
- R1: Register map (4-bit address, byte data, reads are combinational). Unused addresses read 0. The addresses are:
  - 0 control: bit0 calendar on, bit1 chain, bit2 interrupt enable, bit3 interrupt flag.
  - 1 counter A, 2 counter B.
  - 3 second, 4 minute, 5 hour, 6 weekday, 7 day, 8 month.
  - 9 year low byte, 10 year high byte.
- R2: After reset, control and both counters read 0, and second, minute, hour and weekday read 0. Day and month read 1, the year reads the START_YEAR parameter, and the interrupt output is low.
- R3: With chain clear, counter A advances on each cycle with `tick_a_i` and counter B on each cycle with `tick_b_i`. Each wraps from 255 to 0.
- R4: With chain set, counter B advances only in the cycle where counter A wraps from 255, and `tick_b_i` has no effect.
- R5: On a calendar tick, the second wraps after 59, the minute after 59 and the hour after 23, and each wrap carries into the next field.
- R6: The weekday cycles 0 to 6 and advances once on every day change.
- R7: April, June, September and November have 30 days, February has 28, and every other month has 31. After the last day comes day 1 of the next month.
- R8: February has 29 days when the year is divisible by 4 and either not divisible by 100 or divisible by 400.
- R9: After 23:59:59 on December 31 comes January 1, and the 16-bit year increments, carrying across both year bytes.
- R10: A bus write to a count register takes effect even if the same cycle would have incremented that register.
- R11: The flag is set by any of these events, and the interrupt output equals flag AND enable:
  - each minute change in calendar mode;
  - in timer mode, a wrap of counter A with chain clear;
  - in timer mode, a wrap of counter B with chain set.
- R12: Writing control with bit3 = 0 clears the flag, and writing bit3 = 1 leaves it unchanged. A set event in the same cycle as a clear leaves the flag set.
- R13: With the calendar bit clear, `sec_tick_i` leaves all calendar fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_a_i | input | 1 | Count enable for counter A |
| tick_b_i | input | 1 | Count enable for counter B when not chained |
| sec_tick_i | input | 1 | One-second calendar advance |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit counters, a 16-bit year and a start year of 2000. Because the count registers are writable, every wrap can be preloaded and reached in a single tick. This covers the 255-to-0 wraps, the chained 16-bit overflow, and the day, month and year rollovers, including the century years 1900, 2000 and 2100. A table of twelve end-of-day cases exercises the month lengths and the leap rule. Directed cases cover write-over-increment priority, the flag clear race, and the calendar freezing while calendar mode is off.

// File: rtl/rtct_pkg.sv
package rtct_pkg;

    localparam int BYTE_W = 8;
    localparam int YEAR_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] day;
        logic [BYTE_W-1:0] mon;
        logic [YEAR_W-1:0] year;
    } cal_t;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_CNTA  = 4'd1,
        A_CNTB  = 4'd2,
        A_SEC   = 4'd3,
        A_MIN   = 4'd4,
        A_HOUR  = 4'd5,
        A_DOW   = 4'd6,
        A_DAY   = 4'd7,
        A_MON   = 4'd8,
        A_YEARL = 4'd9,
        A_YEARH = 4'd10
    } reg_addr_e;

    // Write strobe indices into the calendar
    localparam int W_SEC   = 0;
    localparam int W_MIN   = 1;
    localparam int W_HOUR  = 2;
    localparam int W_DOW   = 3;
    localparam int W_DAY   = 4;
    localparam int W_MON   = 5;
    localparam int W_YEARL = 6;
    localparam int W_YEARH = 7;
    localparam int N_WR    = 8;

    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        logic by4, by100, by400;
        by4   = (y[1:0] == 2'b00);
        by100 = ((y % 16'd100) == 16'd0);
        by400 = ((y % 16'd400) == 16'd0);
        return by4 && (!by100 || by400);
    endfunction

    function automatic logic [BYTE_W-1:0] month_len(input logic [BYTE_W-1:0] m,
                                                    input logic [YEAR_W-1:0] y);
        logic [BYTE_W-1:0] n;
        case (m)
            8'd2:                    n = leap_year(y) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: n = 8'd30;
            default:                 n = 8'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/byte_counter.sv
module byte_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = inc_i && !ld_i && (st_q.cnt == CNT_MAX);

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i && st_q.cnt == CNT_MAX) |=> (cnt_o == '0));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_o == $past(ld_val_i)));

endmodule

// File: rtl/calendar_core.sv
module calendar_core
    import rtct_pkg::*;
#(
    parameter logic [YEAR_W-1:0] START_YEAR = 16'd2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    input  logic [N_WR-1:0]      wr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    output cal_t                 cal_o,
    output logic                 min_step_o
);
    localparam logic [BYTE_W-1:0] SEC_LAST  = 8'd59;
    localparam logic [BYTE_W-1:0] MIN_LAST  = 8'd59;
    localparam logic [BYTE_W-1:0] HOUR_LAST = 8'd23;
    localparam logic [BYTE_W-1:0] DOW_LAST  = 8'd6;
    localparam logic [BYTE_W-1:0] MON_LAST  = 8'd12;

    cal_t st_d, st_q;

    logic              sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
    logic [BYTE_W-1:0] dim;

    always_comb begin
        dim       = month_len(st_q.mon, st_q.year);
        sec_wrap  = adv_i && (st_q.sec >= SEC_LAST);
        min_wrap  = sec_wrap && (st_q.min >= MIN_LAST);
        hour_wrap = min_wrap && (st_q.hour >= HOUR_LAST);
        day_wrap  = hour_wrap && (st_q.day >= dim);
        mon_wrap  = day_wrap && (st_q.mon >= MON_LAST);

        st_d = st_q;
        if (adv_i) begin
            st_d.sec = sec_wrap ? '0 : st_q.sec + 1'b1;
        end
        if (sec_wrap) begin
            st_d.min = min_wrap ? '0 : st_q.min + 1'b1;
        end
        if (min_wrap) begin
            st_d.hour = hour_wrap ? '0 : st_q.hour + 1'b1;
        end
        if (hour_wrap) begin
            st_d.dow = (st_q.dow >= DOW_LAST) ? '0 : st_q.dow + 1'b1;
            st_d.day = day_wrap ? 8'd1 : st_q.day + 1'b1;
        end
        if (day_wrap) begin
            st_d.mon = mon_wrap ? 8'd1 : st_q.mon + 1'b1;
        end
        if (mon_wrap) begin
            st_d.year = st_q.year + 1'b1;
        end

        // Bus writes override any advance of the same field
        if (wr_i[W_SEC])   st_d.sec  = wdata_i;
        if (wr_i[W_MIN])   st_d.min  = wdata_i;
        if (wr_i[W_HOUR])  st_d.hour = wdata_i;
        if (wr_i[W_DOW])   st_d.dow  = wdata_i;
        if (wr_i[W_DAY])   st_d.day  = wdata_i;
        if (wr_i[W_MON])   st_d.mon  = wdata_i;
        if (wr_i[W_YEARL]) st_d.year[BYTE_W-1:0]      = wdata_i;
        if (wr_i[W_YEARH]) st_d.year[YEAR_W-1:BYTE_W] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sec  <= '0;
            st_q.min  <= '0;
            st_q.hour <= '0;
            st_q.dow  <= '0;
            st_q.day  <= 8'd1;
            st_q.mon  <= 8'd1;
            st_q.year <= START_YEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign cal_o      = st_q;
    assign min_step_o = sec_wrap;

    a_r5_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wr_i == '0 && cal_o.sec == SEC_LAST && cal_o.min < MIN_LAST)
        |=> (cal_o.sec == '0 && cal_o.min == $past(cal_o.min) + 1'b1));

    a_r6_dow_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wr_i == '0 && cal_o.sec == SEC_LAST && cal_o.min == MIN_LAST
         && cal_o.hour == HOUR_LAST && cal_o.dow == DOW_LAST) |=> (cal_o.dow == '0));

    a_r9_year_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wr_i == '0 && cal_o.sec == SEC_LAST && cal_o.min == MIN_LAST
         && cal_o.hour == HOUR_LAST && cal_o.day == 8'd31 && cal_o.mon == MON_LAST)
        |=> (cal_o.year == $past(cal_o.year) + 1'b1 && cal_o.mon == 8'd1 && cal_o.day == 8'd1));

    a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && wr_i == '0) |=> $stable(cal_o));

endmodule

// File: rtl/rtc_cascade_timer.sv
module rtc_cascade_timer
    import rtct_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [YEAR_W-1:0] START_YEAR = 16'd2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a_i,
    input  logic              tick_b_i,
    input  logic              sec_tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int N_CNT   = 2;
    localparam int B_CAL   = 0;
    localparam int B_CHAIN = 1;
    localparam int B_IEN   = 2;
    localparam int B_FLAG  = 3;

    typedef struct packed {
        logic cal_en;
        logic chain;
        logic irq_en;
        logic flag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_CNT-1:0]  cnt_inc, cnt_ld, cnt_wrap;
    logic [BYTE_W-1:0] cnt_val [N_CNT];
    logic [N_WR-1:0]   cal_wr;
    logic              ctl_wr, set_evt, min_step;
    cal_t              cal;

    // Address decode
    always_comb begin
        ctl_wr    = bus_we_i && (bus_addr_i == ADDR_W'(A_CTRL));
        cnt_ld[0] = bus_we_i && (bus_addr_i == ADDR_W'(A_CNTA));
        cnt_ld[1] = bus_we_i && (bus_addr_i == ADDR_W'(A_CNTB));
        cal_wr    = '0;
        if (bus_we_i) begin
            case (bus_addr_i)
                ADDR_W'(A_SEC):   cal_wr[W_SEC]   = 1'b1;
                ADDR_W'(A_MIN):   cal_wr[W_MIN]   = 1'b1;
                ADDR_W'(A_HOUR):  cal_wr[W_HOUR]  = 1'b1;
                ADDR_W'(A_DOW):   cal_wr[W_DOW]   = 1'b1;
                ADDR_W'(A_DAY):   cal_wr[W_DAY]   = 1'b1;
                ADDR_W'(A_MON):   cal_wr[W_MON]   = 1'b1;
                ADDR_W'(A_YEARL): cal_wr[W_YEARL] = 1'b1;
                ADDR_W'(A_YEARH): cal_wr[W_YEARH] = 1'b1;
                default:          cal_wr          = '0;
            endcase
        end
    end

    // Counter enables: B follows A's wrap when chained
    assign cnt_inc[0] = tick_a_i;
    assign cnt_inc[1] = ctl_q.chain ? cnt_wrap[0] : tick_b_i;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        byte_counter #(.W(BYTE_W)) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (cnt_inc[g]),
            .ld_i     (cnt_ld[g]),
            .ld_val_i (bus_wdata_i),
            .cnt_o    (cnt_val[g]),
            .wrap_o   (cnt_wrap[g])
        );
    end

    calendar_core #(.START_YEAR(START_YEAR)) i_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (ctl_q.cal_en && sec_tick_i),
        .wr_i       (cal_wr),
        .wdata_i    (bus_wdata_i),
        .cal_o      (cal),
        .min_step_o (min_step)
    );

    // Interrupt event selection
    always_comb begin
        if (ctl_q.cal_en) begin
            set_evt = min_step;
        end else if (ctl_q.chain) begin
            set_evt = cnt_wrap[1];
        end else begin
            set_evt = cnt_wrap[0];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.cal_en = bus_wdata_i[B_CAL];
            ctl_d.chain  = bus_wdata_i[B_CHAIN];
            ctl_d.irq_en = bus_wdata_i[B_IEN];
            if (!bus_wdata_i[B_FLAG]) begin
                ctl_d.flag = 1'b0;
            end
        end
        if (set_evt) begin
            ctl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(A_CTRL):  bus_rdata_o = {4'b0, ctl_q.flag, ctl_q.irq_en, ctl_q.chain, ctl_q.cal_en};
            ADDR_W'(A_CNTA):  bus_rdata_o = cnt_val[0];
            ADDR_W'(A_CNTB):  bus_rdata_o = cnt_val[1];
            ADDR_W'(A_SEC):   bus_rdata_o = cal.sec;
            ADDR_W'(A_MIN):   bus_rdata_o = cal.min;
            ADDR_W'(A_HOUR):  bus_rdata_o = cal.hour;
            ADDR_W'(A_DOW):   bus_rdata_o = cal.dow;
            ADDR_W'(A_DAY):   bus_rdata_o = cal.day;
            ADDR_W'(A_MON):   bus_rdata_o = cal.mon;
            ADDR_W'(A_YEARL): bus_rdata_o = cal.year[BYTE_W-1:0];
            ADDR_W'(A_YEARH): bus_rdata_o = cal.year[YEAR_W-1:BYTE_W];
            default:          bus_rdata_o = '0;
        endcase
    end

    assign irq_o = ctl_q.flag && ctl_q.irq_en;

    a_r11_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> ctl_q.flag);

    a_r12_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !bus_wdata_i[B_FLAG] && !set_evt) |=> !ctl_q.flag);

    a_r4_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.chain && !cnt_wrap[0] && !cnt_ld[1]) |=> $stable(cnt_val[1]));

    a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctl_q.irq_en && ctl_q.flag));

endmodule

// File: tb/test_rtc_cascade_timer.sv
module test_rtc_cascade_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_a = 1'b0, tick_b = 1'b0, sec_tick = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    rtc_cascade_timer i_rtc_cascade_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_a_i    (tick_a),
        .tick_b_i    (tick_b),
        .sec_tick_i  (sec_tick),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {start year, month, day, expected year, month, day}, time 23:59:59
    localparam logic [63:0] VEC [12] = '{
        {16'd2023, 8'd1,  8'd31, 16'd2023, 8'd2,  8'd1},
        {16'd2023, 8'd2,  8'd28, 16'd2023, 8'd3,  8'd1},
        {16'd2024, 8'd2,  8'd28, 16'd2024, 8'd2,  8'd29},
        {16'd2024, 8'd2,  8'd29, 16'd2024, 8'd3,  8'd1},
        {16'd1900, 8'd2,  8'd28, 16'd1900, 8'd3,  8'd1},
        {16'd2000, 8'd2,  8'd28, 16'd2000, 8'd2,  8'd29},
        {16'd2023, 8'd4,  8'd30, 16'd2023, 8'd5,  8'd1},
        {16'd2023, 8'd12, 8'd31, 16'd2024, 8'd1,  8'd1},
        {16'd2023, 8'd6,  8'd15, 16'd2023, 8'd6,  8'd16},
        {16'd2100, 8'd2,  8'd28, 16'd2100, 8'd3,  8'd1},
        {16'd2023, 8'd9,  8'd30, 16'd2023, 8'd10, 8'd1},
        {16'd2255, 8'd12, 8'd31, 16'd2256, 8'd1,  8'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, int'(v), exp);
    endtask

    task automatic pulse(input logic pa, input logic pb, input logic ps);
        @(negedge clk);
        tick_a = pa; tick_b = pb; sec_tick = ps;
        @(negedge clk);
        tick_a = 1'b0; tick_b = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic set_time(input int y, input int m, input int d,
                            input int h, input int mi, input int s, input int w);
        wr(4'd10, 8'(y >> 8));
        wr(4'd9,  8'(y));
        wr(4'd8,  8'(m));
        wr(4'd7,  8'(d));
        wr(4'd5,  8'(h));
        wr(4'd4,  8'(mi));
        wr(4'd3,  8'(s));
        wr(4'd6,  8'(w));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state (R1 addresses)
        check("R2 irq", int'(irq), 0);
        rd_chk("R2 ctrl", 4'd0, 0);
        rd_chk("R2 cnt A", 4'd1, 0);
        rd_chk("R2 cnt B", 4'd2, 0);
        rd_chk("R2 sec", 4'd3, 0);
        rd_chk("R2 dow", 4'd6, 0);
        rd_chk("R2 day", 4'd7, 1);
        rd_chk("R2 month", 4'd8, 1);
        rd_chk("R2 year lo", 4'd9, 2000 & 255);
        rd_chk("R2 year hi", 4'd10, 2000 >> 8);
        rd_chk("R1 unused addr", 4'd15, 0);

        // Table of end-of-day rollovers: R7 R8 R9 R6 R5 R11
        wr(4'd0, 8'h01);
        foreach (VEC[i]) begin
            set_time(int'(VEC[i][63:48]), int'(VEC[i][47:40]), int'(VEC[i][39:32]), 23, 59, 59, 6);
            pulse(1'b0, 1'b0, 1'b1);
            rd_chk($sformatf("R7/R8 vec%0d day", i), 4'd7, int'(VEC[i][7:0]));
            rd_chk($sformatf("R7/R8 vec%0d month", i), 4'd8, int'(VEC[i][15:8]));
            rd_chk($sformatf("R9 vec%0d year lo", i), 4'd9, int'(VEC[i][23:16]));
            rd_chk($sformatf("R9 vec%0d year hi", i), 4'd10, int'(VEC[i][31:24]));
            rd_chk($sformatf("R5 vec%0d hour", i), 4'd5, 0);
            rd_chk($sformatf("R5 vec%0d sec", i), 4'd3, 0);
            rd_chk($sformatf("R6 vec%0d dow", i), 4'd6, 0);
            rd_chk($sformatf("R11 vec%0d minute flag", i), 4'd0, 8'h09);
            wr(4'd0, 8'h01);
        end

        // R5 plain second and minute carry
        set_time(2023, 3, 3, 10, 10, 10, 2);
        pulse(1'b0, 1'b0, 1'b1);
        rd_chk("R5 sec step", 4'd3, 11);
        rd_chk("R11 no flag without minute change", 4'd0, 8'h01);
        wr(4'd3, 8'd59);
        pulse(1'b0, 1'b0, 1'b1);
        rd_chk("R5 sec wrap", 4'd3, 0);
        rd_chk("R5 min carry", 4'd4, 11);
        rd_chk("R5 hour kept", 4'd5, 10);
        rd_chk("R6 dow kept", 4'd6, 2);

        // R10 write beats calendar advance in same cycle
        @(negedge clk);
        addr = 4'd3; wdata = 8'd40; we = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        we = 1'b0; sec_tick = 1'b0;
        rd_chk("R10 sec write wins", 4'd3, 40);

        // R13 calendar frozen when off
        wr(4'd0, 8'h00);
        pulse(1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        rd_chk("R13 sec frozen", 4'd3, 40);

        // R3 independent counters
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        rd_chk("R3 A counts", 4'd1, 3);
        rd_chk("R3 B untouched", 4'd2, 0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, 1'b0);
        rd_chk("R3 B counts", 4'd2, 2);
        wr(4'd1, 8'hFF);
        pulse(1'b1, 1'b0, 1'b0);
        rd_chk("R3 A wraps", 4'd1, 0);
        rd_chk("R11 A wrap sets flag", 4'd0, 8'h08);
        check("R11 irq masked", int'(irq), 0);
        wr(4'd0, 8'h0C);
        rd_chk("R12 write 1 keeps flag", 4'd0, 8'h0C);
        @(negedge clk);
        check("R11 irq on", int'(irq), 1);
        wr(4'd0, 8'h04);
        @(negedge clk);
        check("R12 clear irq", int'(irq), 0);
        rd_chk("R12 flag cleared", 4'd0, 8'h04);

        // R10 counter write beats increment
        @(negedge clk);
        addr = 4'd1; wdata = 8'd7; we = 1'b1; tick_a = 1'b1;
        @(negedge clk);
        we = 1'b0; tick_a = 1'b0;
        rd_chk("R10 counter write wins", 4'd1, 7);

        // R4 chained counting
        wr(4'd0, 8'h06);
        wr(4'd1, 8'hFF);
        wr(4'd2, 8'h10);
        pulse(1'b0, 1'b1, 1'b0);
        rd_chk("R4 tick_b ignored", 4'd2, 8'h10);
        pulse(1'b1, 1'b0, 1'b0);
        rd_chk("R4 A wrapped", 4'd1, 0);
        rd_chk("R4 B carried", 4'd2, 8'h11);
        rd_chk("R11 chain A wrap no flag", 4'd0, 8'h06);
        pulse(1'b1, 1'b0, 1'b0);
        rd_chk("R4 B steady", 4'd2, 8'h11);
        wr(4'd1, 8'hFF);
        wr(4'd2, 8'hFF);
        pulse(1'b1, 1'b0, 1'b0);
        rd_chk("R4 16-bit wrap lo", 4'd1, 0);
        rd_chk("R4 16-bit wrap hi", 4'd2, 0);
        rd_chk("R11 chain overflow flag", 4'd0, 8'h0E);
        check("R11 chain irq", int'(irq), 1);

        // R12 set wins over clear in same cycle
        wr(4'd0, 8'h00);
        wr(4'd1, 8'hFF);
        @(negedge clk);
        addr = 4'd0; wdata = 8'h00; we = 1'b1; tick_a = 1'b1;
        @(negedge clk);
        we = 1'b0; tick_a = 1'b0;
        rd(4'd0, v);
        check("R12 set beats clear", int'(v[3]), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule